// File: doc/BRIEF.md
# Two-Pass Double-Word Adder

This block adds two double-word operands with a single word-wide adder that it uses twice. Each operand comes in as a low word and a high word. A one-cycle start pulse, taken while the block is idle, captures both operands. On the next clock edge the low words are added and the carry out of that addition is held in a register. On the edge after that, the high words are added together with the held carry. The block then raises a one-cycle done pulse with the double-word sum. It also reports the carry out of the top bit and a signed-overflow flag.

A second path rebuilds the low-word carry from three sign bits: the two low operand words and the low result. A bound checker compares this rebuilt carry with the adder's real carry. The block is meant for a narrow datapath that sometimes needs wide arithmetic and can afford two adder cycles instead of a second adder.

Top module: `dword_seq_adder`

## Requirements
- R1: After reset, busy, done, carry_out, overflow, sum_lo and sum_hi are all 0.
- R2: sum_lo equals (a_lo + b_lo) modulo 2^WORD_W, using the operands captured at start.
- R3: sum_hi equals (a_hi + b_hi + k) modulo 2^WORD_W, where k is the carry out of the low-word addition. The high addition only ever happens in the cycle after the low addition.
- R4: carry_out is bit 2*WORD_W of the full double-word sum {a_hi,a_lo} + {b_hi,b_lo}. The result is laid out as sum_hi in bits 2*WORD_W-1:WORD_W and sum_lo in bits WORD_W-1:0.
- R5: overflow is 1 exactly when the carry into bit 2*WORD_W-1 differs from the carry out of it. Equivalently, both operands have the same sign and the sign of the result differs from it.
- R6: A start pulse sampled at a rising edge while idle sets busy from that edge. done is high for exactly one cycle, starting at the third rising edge counted from and including the sampling edge. busy falls together with done.
- R7: A start pulse while busy is ignored. It does not change the captured operands or the result, and it causes no second done pulse. Operand inputs that change while busy have no effect either.
- R8: The low carry rebuilt from sign bits, (a&b) | (a&~s) | (b&~s) with a, b the low operand MSBs and s the low result MSB, always equals the adder's true low carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an addition (taken only when idle) |
| a_lo | input | WORD_W | Operand A, low word |
| a_hi | input | WORD_W | Operand A, high word |
| b_lo | input | WORD_W | Operand B, low word |
| b_hi | input | WORD_W | Operand B, high word |
| busy | output | 1 | An addition is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| sum_lo | output | WORD_W | Result, low word |
| sum_hi | output | WORD_W | Result, high word |
| carry_out | output | 1 | Carry out of the double-word sum |
| overflow | output | 1 | Signed overflow of the double-word sum |

## Verification
The hardest case to reach from the ports is a low-word carry that must propagate into the high word while the high words alone would produce no carry. The sign-bit carry rebuild must also agree with the true carry on every mix of operand and result signs. A narrow instance with 3-bit words is swept over every operand pair, so every carry pattern occurs. During each operation a start pulse with inverted operands is injected to show that it is ignored. A full-width instance then runs directed vectors: a low word of all ones plus one, full-width wrap-around, and both signs of overflow.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Carry of an addition rebuilt from sign bits only:
  // x, y are operand MSBs, s is the result MSB.
  function automatic logic sign_carry(input logic x, input logic y, input logic s);
    return (x & y) | (x & ~s) | (y & ~s);
  endfunction

endpackage

// File: rtl/dsa_word_adder.sv
module dsa_word_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout,
  output logic         c_into_msb
);

  localparam int LW = W - 1;

  // Full sum including carry out.
  function automatic logic [W:0] add_full(input logic [W-1:0] p, input logic [W-1:0] q,
                                          input logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  // Carry into the top bit: sum of the lower W-1 bits.
  function automatic logic add_msb_cin(input logic [W-1:0] p, input logic [W-1:0] q,
                                       input logic ci);
    logic [LW:0] t;
    t = {1'b0, p[LW-1:0]} + {1'b0, q[LW-1:0]} + {{LW{1'b0}}, ci};
    return t[LW];
  endfunction

  logic [W:0] full;

  always_comb begin
    full       = add_full(x, y, cin);
    s          = full[W-1:0];
    cout       = full[W];
    c_into_msb = add_msb_cin(x, y, cin);
  end

endmodule

// File: rtl/dsa_carry_recon.sv
module dsa_carry_recon (
  input  logic x_msb,
  input  logic y_msb,
  input  logic s_msb,
  output logic carry
);
  import dsa_pkg::*;

  always_comb carry = sign_carry(x_msb, y_msb, s_msb);

endmodule

// File: rtl/dsa_phase_ctrl.sv
module dsa_phase_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output dsa_pkg::phase_e phase,
  output logic            load,
  output logic            busy,
  output logic            done
);
  import dsa_pkg::*;

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_LOW;
      PH_LOW:  phase_d = PH_HIGH;
      PH_HIGH: phase_d = PH_DONE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
  assign load  = (phase_q == PH_IDLE) && start;
  assign busy  = (phase_q != PH_IDLE);
  assign done  = (phase_q == PH_DONE);

endmodule

// File: rtl/dword_seq_adder.sv
module dword_seq_adder #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] a_lo,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [WORD_W-1:0] b_lo,
  input  logic [WORD_W-1:0] b_hi,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] sum_lo,
  output logic [WORD_W-1:0] sum_hi,
  output logic              carry_out,
  output logic              overflow
);
  import dsa_pkg::*;

  localparam int DW = 2 * WORD_W;

  phase_e            phase;
  logic              load;
  logic              lo_phase, hi_phase;
  logic [DW-1:0]     opa_q, opb_q;
  logic [WORD_W-1:0] add_x, add_y, add_s;
  logic              add_cin, add_cout, add_cmsb;
  logic              lo_carry_q;
  logic              lo_carry_true, lo_carry_recon;
  logic [WORD_W-1:0] sum_lo_q, sum_hi_q;
  logic              c_out_q, v_q;

  dsa_phase_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase),
    .load  (load),
    .busy  (busy),
    .done  (done)
  );

  assign lo_phase = (phase == PH_LOW);
  assign hi_phase = (phase == PH_HIGH);

  // One adder shared by both passes.
  always_comb begin
    if (hi_phase) begin
      add_x   = opa_q[DW-1:WORD_W];
      add_y   = opb_q[DW-1:WORD_W];
      add_cin = lo_carry_q;
    end else begin
      add_x   = opa_q[WORD_W-1:0];
      add_y   = opb_q[WORD_W-1:0];
      add_cin = 1'b0;
    end
  end

  dsa_word_adder #(.W(WORD_W)) u_add (
    .x          (add_x),
    .y          (add_y),
    .cin        (add_cin),
    .s          (add_s),
    .cout       (add_cout),
    .c_into_msb (add_cmsb)
  );

  assign lo_carry_true = add_cout;

  dsa_carry_recon u_recon (
    .x_msb (opa_q[WORD_W-1]),
    .y_msb (opb_q[WORD_W-1]),
    .s_msb (add_s[WORD_W-1]),
    .carry (lo_carry_recon)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q      <= '0;
      opb_q      <= '0;
      lo_carry_q <= 1'b0;
      sum_lo_q   <= '0;
      sum_hi_q   <= '0;
      c_out_q    <= 1'b0;
      v_q        <= 1'b0;
    end else begin
      if (load) begin
        opa_q <= {a_hi, a_lo};
        opb_q <= {b_hi, b_lo};
      end
      if (lo_phase) begin
        sum_lo_q   <= add_s;
        lo_carry_q <= add_cout;
      end
      if (hi_phase) begin
        sum_hi_q <= add_s;
        c_out_q  <= add_cout;
        v_q      <= add_cmsb ^ add_cout;
      end
    end
  end

  assign sum_lo    = sum_lo_q;
  assign sum_hi    = sum_hi_q;
  assign carry_out = c_out_q;
  assign overflow  = v_q;

endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           lo_phase,
  input logic           hi_phase,
  input logic           lo_carry_true,
  input logic           lo_carry_recon,
  input logic [2*W-1:0] opa_q,
  input logic [2*W-1:0] opb_q,
  input logic [W-1:0]   sum_lo,
  input logic [W-1:0]   sum_hi,
  input logic           carry_out,
  input logic           overflow
);

  a_r8_carry_recon: assert property (@(posedge clk) disable iff (!rst_n)
    lo_phase |-> (lo_carry_recon == lo_carry_true));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    hi_phase |-> $past(lo_phase));

  a_r7_ops_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(opa_q) && $stable(opb_q)));

  a_r4_full_sum: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({carry_out, sum_hi, sum_lo} == ({1'b0, opa_q} + {1'b0, opb_q})));

  a_r5_overflow_sign: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (overflow == ((opa_q[2*W-1] == opb_q[2*W-1]) &&
                           (sum_hi[W-1] != opa_q[2*W-1]))));

endmodule

bind dword_seq_adder dsa_checker #(.W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .busy           (busy),
  .done           (done),
  .lo_phase       (lo_phase),
  .hi_phase       (hi_phase),
  .lo_carry_true  (lo_carry_true),
  .lo_carry_recon (lo_carry_recon),
  .opa_q          (opa_q),
  .opb_q          (opb_q),
  .sum_lo         (sum_lo),
  .sum_hi         (sum_hi),
  .carry_out      (carry_out),
  .overflow       (overflow)
);

// File: tb/dword_seq_adder_test.sv
module dword_seq_adder_test;

  localparam int WW = 32;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // Wide instance
  logic          w_start = 1'b0;
  logic [WW-1:0] w_alo = '0, w_ahi = '0, w_blo = '0, w_bhi = '0;
  logic          w_busy, w_done, w_c, w_v;
  logic [WW-1:0] w_slo, w_shi;

  dword_seq_adder #(.WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .start(w_start),
    .a_lo(w_alo), .a_hi(w_ahi), .b_lo(w_blo), .b_hi(w_bhi),
    .busy(w_busy), .done(w_done), .sum_lo(w_slo), .sum_hi(w_shi),
    .carry_out(w_c), .overflow(w_v)
  );

  // Narrow instance for the exhaustive sweep
  logic          s_start = 1'b0;
  logic [SW-1:0] s_alo = '0, s_ahi = '0, s_blo = '0, s_bhi = '0;
  logic          s_busy, s_done, s_c, s_v;
  logic [SW-1:0] s_slo, s_shi;

  dword_seq_adder #(.WORD_W(SW)) uut_small (
    .clk(clk), .rst_n(rst_n), .start(s_start),
    .a_lo(s_alo), .a_hi(s_ahi), .b_lo(s_blo), .b_hi(s_bhi),
    .busy(s_busy), .done(s_done), .sum_lo(s_slo), .sum_hi(s_shi),
    .carry_out(s_c), .overflow(s_v)
  );

  task automatic chk(input bit ok, input string req, input logic [64:0] act,
                     input logic [64:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  // Full-width operation with a start poke while busy (R7)
  task automatic run_wide(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] e;
    logic        ev;
    e  = {1'b0, a} + {1'b0, b};
    ev = (a[63] == b[63]) && (e[63] != a[63]);
    @(negedge clk);
    w_start = 1'b1; {w_ahi, w_alo} = a; {w_bhi, w_blo} = b;
    @(negedge clk);
    chk(w_busy == 1'b1, "R6 busy after start", {64'd0, w_busy}, 65'd1);
    w_start = 1'b1; {w_ahi, w_alo} = ~a; {w_bhi, w_blo} = ~b;
    @(negedge clk);
    w_start = 1'b0;
    chk(w_done == 1'b0, "R6 done early", {64'd0, w_done}, 65'd0);
    @(negedge clk);
    chk(w_done == 1'b1, "R6 done pulse", {64'd0, w_done}, 65'd1);
    chk(w_slo == e[31:0], "R2 low word", {33'd0, w_slo}, {33'd0, e[31:0]});
    chk(w_shi == e[63:32], "R3 high word with carry", {33'd0, w_shi}, {33'd0, e[63:32]});
    chk(w_c == e[64], "R4 carry out", {64'd0, w_c}, {64'd0, e[64]});
    chk(w_v == ev, "R5 overflow", {64'd0, w_v}, {64'd0, ev});
    @(negedge clk);
    chk(w_done == 1'b0 && w_busy == 1'b0, "R6 R7 single done, idle after",
        {63'd0, w_done, w_busy}, 65'd0);
  endtask

  // Narrow operation, aggregated check; start poke with inverted operands
  task automatic run_small(input logic [5:0] a, input logic [5:0] b);
    logic [6:0] e;
    logic       ev;
    logic [6:0] got;
    bit         ok;
    e  = {1'b0, a} + {1'b0, b};
    ev = (a[5] == b[5]) && (e[5] != a[5]);
    @(negedge clk);
    s_start = 1'b1; {s_ahi, s_alo} = a; {s_bhi, s_blo} = b;
    @(negedge clk);
    s_start = 1'b1; {s_ahi, s_alo} = ~a; {s_bhi, s_blo} = ~b;
    @(negedge clk);
    s_start = 1'b0;
    ok = (s_done == 1'b0);
    @(negedge clk);
    got = {s_c, s_shi, s_slo};
    ok = ok && s_done && (got == e) && (s_v == ev);
    chk(ok, "R2 R3 R4 R5 R8 sweep", {57'd0, s_v, got}, {57'd0, ev, e});
    @(negedge clk);
    chk(!s_done && !s_busy, "R7 sweep no extra done", {63'd0, s_done, s_busy}, 65'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!w_busy && !w_done && !w_c && !w_v && w_slo == 0 && w_shi == 0,
        "R1 reset state", {33'd0, w_shi, w_slo}, 65'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!w_busy && !w_done, "R1 idle after reset", {63'd0, w_busy, w_done}, 65'd0);

    // Low word all ones plus one: carry ripples into high word (R3, R8)
    run_wide(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    run_wide(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);  // R4 wrap
    run_wide(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);  // R5 positive ovf
    run_wide(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);  // R5 negative ovf
    run_wide(64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFC);
    run_wide(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
    run_wide(64'h0, 64'h0);

    // Exhaustive narrow sweep over all operand pairs
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        run_small(i[5:0], j[5:0]);

    summary();
  end

endmodule